// File: doc/BRIEF.md
# Event Timer Register File

This block is the register window of a multi-channel event timer. It decodes a 1 KiB space reached over a plain 32-bit read/write bus. It holds the global capability, configuration and status words, the 64-bit main counter, and three 64-bit registers for each channel: configuration, comparator and route. Each 64-bit register is reached as two 32-bit halves. The block owns the main counter. The counter advances on a tick enable while the global enable bit is set, and holds its value while that bit is clear.

The channel timing logic and the interrupt router sit beside this block. They receive the stored fields on flat output buses, plus single-cycle arm, disarm and status-clear strobes. The block detects enable edges by comparing each stored bit with the value being written in the same access. Read data is combinational from the address.

Top module: `evt_timer_regs`

## Requirements
- R1: After reset the main counter and the global configuration read zero, every channel comparator reads all ones, every channel route reads zero, and every channel configuration low word reads 0x30.
- R2: The capability low word at byte offset 0x000 reads {16'h0, bit15=1 (legacy routing), bit14=0, bit13=1 (64-bit counter), bits12:8 = channels minus one, bits7:0 = 0x01}. The high word at 0x004 reads the tick period in femtoseconds. Writes to both words are ignored.
- R3: The global configuration word at 0x010 stores only bit 0 (enable) and bit 1 (legacy routing). All other bits read zero. The two stored bits drive `glb_en` and `legacy_en`.
- R4: The counter halves at 0x0F0 (low) and 0x0F4 (high) take writes only while the enable is clear. Writes made while the enable is set leave the counter unchanged.
- R5: While enabled, the counter adds one on every clock edge where `tick` is high, and carries from the low half into the high half. While disabled, the counter holds its value and resumes from that value on the next enable.
- R6: A write that raises the global enable pulses `ch_arm` for one cycle, in the cycle after the write, for every channel whose comparator is not all ones. A write that clears the global enable pulses `ch_disarm` for every channel.
- R7: Channel n occupies 0x100 + n*0x20: configuration at +0x0, comparator at +0x8, route at +0x10, each as low then high word. The configuration low word stores only the bits in mask 0x7F4E. Bits 4 and 5 always read 1. The high word always reads 0x4 and ignores writes. A rise of bit 2 in a write pulses that channel's `ch_arm`, and a fall pulses its `ch_disarm`.
- R8: A configuration write with bit 8 (32-bit mode) set clears that channel's comparator high word in the same cycle. While bit 8 is stored, writes to the comparator high word are ignored.
- R9: The following read zero and ignore writes: unmapped offsets, channel slots at or beyond the channel count, words +0x18 and +0x1C of a slot, and any address with bits 1:0 nonzero.
- R10: The status word at 0x020 reads `irq_sts`. A write there pulses `sts_clr` for one cycle with the written low bits.
- R11: The route register of each channel stores all 64 bits, written and read as two halves, and appears on `ch_route_o`.
- R12: A counter read while counting returns the live value in that cycle. No snapshot is taken, so two reads N ticking cycles apart differ by N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Counter advance enable |
| bus_sel | input | 1 | Access select |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 10 | Byte address in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| irq_sts | input | NCH | Per-channel interrupt status from channel logic |
| glb_en | output | 1 | Global enable bit |
| legacy_en | output | 1 | Legacy routing bit |
| count | output | 64 | Main counter |
| ch_cfg_o | output | NCH*32 | Channel configuration low words |
| ch_cmp_o | output | NCH*64 | Channel comparators |
| ch_route_o | output | NCH*64 | Channel route words |
| ch_arm | output | NCH | One-cycle re-arm strobes |
| ch_disarm | output | NCH | One-cycle disarm strobes |
| sts_clr | output | NCH | One-cycle status clear strobes |

## Verification
A corrupt stored field shows up on the very next read of its address. It also shows up on the flat channel outputs in the cycle after the write that caused it. An edge detector that compares the wrong value gives a missing or extra arm or disarm strobe one cycle after the configuration write. A counter that steps on the wrong condition drifts from the expected tick count at the next counter read. A bad carry shows only when the low half wraps, so the bench starts the count just below a wrap.

// File: rtl/evt_timer_regs.sv
`timescale 1ns/1ps
module evt_timer_regs #(
  parameter int          NCH       = 3,
  parameter logic [31:0] PERIOD_FS = 32'd10000000,
  parameter logic [31:0] CH_WMASK  = 32'h0000_7F4E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [9:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NCH-1:0]    irq_sts,
  output logic              glb_en,
  output logic              legacy_en,
  output logic [63:0]       count,
  output logic [NCH*32-1:0] ch_cfg_o,
  output logic [NCH*64-1:0] ch_cmp_o,
  output logic [NCH*64-1:0] ch_route_o,
  output logic [NCH-1:0]    ch_arm,
  output logic [NCH-1:0]    ch_disarm,
  output logic [NCH-1:0]    sts_clr
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [31:0] CAP_LO = {16'h0, 3'b101, 5'(NCH-1), 8'h01};
  localparam logic [31:0] CFG_RO = 32'h0000_0030;
  localparam logic [31:0] CFG_HI = 32'h0000_0004;

  logic [1:0]  gcfg;
  logic [31:0] ch_cfg [NCH];
  logic [63:0] ch_cmp [NCH];
  logic [63:0] ch_rt  [NCH];

  wire          aligned = bus_addr[1:0] == 2'b00;
  wire          wr      = bus_sel & bus_wr & aligned;
  wire          in_ch   = bus_addr[9:8] != 2'b00;
  wire [4:0]    cidx    = bus_addr[9:5] - 5'd8;
  wire [IW-1:0] ci      = cidx[IW-1:0];
  wire [2:0]    woff    = bus_addr[4:2];
  wire          ch_hit  = in_ch && (32'(cidx) < NCH);
  wire [7:0]    gword   = bus_addr[9:2];

  assign glb_en    = gcfg[0];
  assign legacy_en = gcfg[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gcfg      <= '0;
      count     <= '0;
      ch_arm    <= '0;
      ch_disarm <= '0;
      sts_clr   <= '0;
      for (int i = 0; i < NCH; i++) begin
        ch_cfg[i] <= '0;
        ch_cmp[i] <= '1;
        ch_rt[i]  <= '0;
      end
    end else begin
      ch_arm    <= '0;
      ch_disarm <= '0;
      sts_clr   <= '0;
      if (gcfg[0] && tick) count <= count + 64'd1;
      if (wr && !in_ch) begin
        case (gword)
          8'h04: begin
            gcfg <= bus_wdata[1:0];
            if (!gcfg[0] && bus_wdata[0])
              for (int i = 0; i < NCH; i++) ch_arm[i] <= ch_cmp[i] != '1;
            else if (gcfg[0] && !bus_wdata[0])
              ch_disarm <= '1;
          end
          8'h08: sts_clr <= bus_wdata[NCH-1:0];
          8'h3C: if (!gcfg[0]) count[31:0]  <= bus_wdata;
          8'h3D: if (!gcfg[0]) count[63:32] <= bus_wdata;
          default: ;
        endcase
      end
      if (wr && ch_hit) begin
        case (woff)
          3'd0: begin
            ch_cfg[ci] <= bus_wdata & CH_WMASK;
            if (!ch_cfg[ci][2] && bus_wdata[2])      ch_arm[ci]    <= 1'b1;
            else if (ch_cfg[ci][2] && !bus_wdata[2]) ch_disarm[ci] <= 1'b1;
            if (bus_wdata[8]) ch_cmp[ci][63:32] <= '0;
          end
          3'd2: ch_cmp[ci][31:0] <= bus_wdata;
          3'd3: if (!ch_cfg[ci][8]) ch_cmp[ci][63:32] <= bus_wdata;
          3'd4: ch_rt[ci][31:0]  <= bus_wdata;
          3'd5: ch_rt[ci][63:32] <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      if (in_ch) begin
        if (ch_hit) begin
          case (woff)
            3'd0: bus_rdata = ch_cfg[ci] | CFG_RO;
            3'd1: bus_rdata = CFG_HI;
            3'd2: bus_rdata = ch_cmp[ci][31:0];
            3'd3: bus_rdata = ch_cmp[ci][63:32];
            3'd4: bus_rdata = ch_rt[ci][31:0];
            3'd5: bus_rdata = ch_rt[ci][63:32];
            default: bus_rdata = '0;
          endcase
        end
      end else begin
        case (gword)
          8'h00: bus_rdata = CAP_LO;
          8'h01: bus_rdata = PERIOD_FS;
          8'h04: bus_rdata = {30'b0, gcfg};
          8'h08: bus_rdata = 32'(irq_sts);
          8'h3C: bus_rdata = count[31:0];
          8'h3D: bus_rdata = count[63:32];
          default: bus_rdata = '0;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign ch_cfg_o[g*32 +: 32]   = ch_cfg[g] | CFG_RO;
    assign ch_cmp_o[g*64 +: 64]   = ch_cmp[g];
    assign ch_route_o[g*64 +: 64] = ch_rt[g];

    // R8
    trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_cfg[g][8] |-> ch_cmp[g][63:32] == 32'h0);
  end

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    glb_en && tick |=> count == $past(count) + 64'd1);

  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    glb_en && !tick |=> $stable(count));

  // R6
  disarm_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(glb_en) |-> ch_disarm == '1);

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_arm & ch_disarm) == '0);
endmodule

// File: tb/test_evt_timer_regs.sv
`timescale 1ns/1ps
module test_evt_timer_regs;
  localparam int NCH = 3;
  logic clk = 0, rst_n = 0, tick = 0, bus_sel = 0, bus_wr = 0;
  logic [9:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NCH-1:0] irq_sts = '0, ch_arm, ch_disarm, sts_clr;
  logic glb_en, legacy_en;
  logic [63:0] count;
  logic [NCH*32-1:0] ch_cfg_o;
  logic [NCH*64-1:0] ch_cmp_o, ch_route_o;
  logic [NCH-1:0] s_arm, s_disarm, s_clr;
  int checks = 0, fails = 0;
  bit done = 0;

  evt_timer_regs #(.NCH(NCH)) i_evt_timer_regs (.*);

  always #5 clk = ~clk;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    s_arm = ch_arm; s_disarm = ch_disarm; s_clr = sts_clr;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(10'h0F0, d); chk("R1 cnt lo", d, 0);
    rd(10'h0F4, d); chk("R1 cnt hi", d, 0);
    rd(10'h010, d); chk("R1 gcfg", d, 0);
    rd(10'h108, d); chk("R1 cmp lo", d, 32'hFFFFFFFF);
    rd(10'h14C, d); chk("R1 cmp hi ch2", d, 32'hFFFFFFFF);
    rd(10'h130, d); chk("R1 route ch1", d, 0);
    rd(10'h100, d); chk("R1 cfg ch0", d, 32'h30);
  endtask

  task automatic t_cap;
    logic [31:0] d;
    rd(10'h000, d); chk("R2 cap lo", d, 32'h0000A201);
    rd(10'h004, d); chk("R2 cap hi", d, 32'd10000000);
    wr(10'h000, 32'h12345678); wr(10'h004, 0);
    rd(10'h000, d); chk("R2 cap lo after write", d, 32'h0000A201);
    rd(10'h004, d); chk("R2 cap hi after write", d, 32'd10000000);
  endtask

  task automatic t_gcfg;
    logic [31:0] d;
    wr(10'h010, 32'hFFFFFFFE);
    rd(10'h010, d); chk("R3 gcfg mask", d, 32'h2);
    chk("R3 legacy_en", legacy_en, 1); chk("R3 glb_en", glb_en, 0);
    wr(10'h010, 0);
  endtask

  task automatic t_counter;
    logic [31:0] d;
    wr(10'h0F0, 32'hFFFFFFFE); wr(10'h0F4, 32'h1);
    rd(10'h0F0, d); chk("R4 cnt lo write", d, 32'hFFFFFFFE);
    rd(10'h0F4, d); chk("R4 cnt hi write", d, 32'h1);
    wr(10'h010, 1);
    chk("R6 no arm when all cmps all ones", s_arm, 0);
    wr(10'h0F0, 32'h55);
    rd(10'h0F0, d); chk("R4 write ignored when enabled", d, 32'hFFFFFFFE);
    @(negedge clk); tick = 1;
    repeat (4) @(negedge clk);
    tick = 0;
    wr(10'h010, 0);
    rd(10'h0F0, d); chk("R5 count lo after carry", d, 32'h2);
    rd(10'h0F4, d); chk("R5 count hi after carry", d, 32'h2);
    @(negedge clk); tick = 1; repeat (3) @(negedge clk); tick = 0;
    rd(10'h0F0, d); chk("R5 holds while disabled", d, 32'h2);
  endtask

  task automatic t_live;
    logic [31:0] a, b;
    wr(10'h0F0, 32'h100); wr(10'h0F4, 0);
    wr(10'h010, 1);
    @(negedge clk); tick = 1; bus_sel = 1; bus_wr = 0; bus_addr = 10'h0F0;
    #1 a = bus_rdata;
    repeat (3) @(negedge clk);
    #1 b = bus_rdata;
    tick = 0;
    chk("R12 live read delta", b - a, 3);
    wr(10'h010, 0);
  endtask

  task automatic t_rearm;
    wr(10'h128, 32'h10);
    wr(10'h010, 1);
    chk("R6 arm on enable rise", s_arm, 3'b010);
    chk("R6 no disarm on rise", s_disarm, 0);
    wr(10'h010, 0);
    chk("R6 disarm all on fall", s_disarm, 3'b111);
    chk("R6 no arm on fall", s_arm, 0);
  endtask

  task automatic t_chcfg;
    logic [31:0] d;
    wr(10'h100, 32'hFFFFFFFF);
    rd(10'h100, d); chk("R7 cfg mask", d, 32'h7F7E);
    chk("R7 arm on ch enable rise", s_arm, 3'b001);
    wr(10'h104, 32'hFFFFFFFF);
    rd(10'h104, d); chk("R7 cfg hi read-only", d, 32'h4);
    rd(10'h10C, d); chk("R8 cmp hi truncated", d, 0);
    wr(10'h10C, 32'h1234);
    rd(10'h10C, d); chk("R8 cmp hi write ignored in 32-bit mode", d, 0);
    wr(10'h100, 0);
    chk("R7 disarm on ch enable fall", s_disarm, 3'b001);
    rd(10'h100, d); chk("R7 cfg cleared", d, 32'h30);
    wr(10'h10C, 32'h1234);
    rd(10'h10C, d); chk("R8 cmp hi writable in 64-bit mode", d, 32'h1234);
    chk("R8 cmp on output", ch_cmp_o[63:0], 64'h00001234_FFFFFFFF);
  endtask

  task automatic t_route;
    logic [31:0] d;
    wr(10'h150, 32'hCAFE0001); wr(10'h154, 32'h0BAD0002);
    rd(10'h150, d); chk("R11 route lo", d, 32'hCAFE0001);
    rd(10'h154, d); chk("R11 route hi", d, 32'h0BAD0002);
    chk("R11 route output", ch_route_o[128 +: 64], 64'h0BAD0002_CAFE0001);
  endtask

  task automatic t_status;
    logic [31:0] d;
    irq_sts = 3'b101;
    rd(10'h020, d); chk("R10 status read", d, 32'h5);
    wr(10'h020, 32'h6);
    chk("R10 clear strobe", s_clr, 3'b110);
    @(negedge clk); chk("R10 strobe one cycle", sts_clr, 0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    rd(10'h00C, d); chk("R9 unmapped global", d, 0);
    rd(10'h118, d); chk("R9 slot word 6", d, 0);
    wr(10'h160, 32'hFFFFFFFF);
    rd(10'h160, d); chk("R9 slot beyond count", d, 0);
    rd(10'h140, d); chk("R9 ch2 cfg untouched", d, 32'h30);
    wr(10'h0F8, 32'hFFFFFFFF); wr(10'h0F2, 32'hFFFFFFFF);
    rd(10'h0F0, d); chk("R9 counter untouched", d, 32'h103);
    rd(10'h002, d); chk("R9 misaligned read", d, 0);
  endtask

  initial begin
    #2ms;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_cap; t_gcfg; t_counter; t_live;
    t_rearm; t_chcfg; t_route; t_status; t_unmapped;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule